// File: doc/BRIEF.md
# Chipset Configuration Register Port

This block is a byte-wide configuration register file that a processor reaches through a pair of adjacent I/O ports. In the system, the pair occupies I/O addresses 00A8h (even, index) and 00A9h (odd, data). An external decoder qualifies the strobes for that pair, and the block sees only address bit 0. A write to the even port stores an 8-bit index. Accesses to the odd port then read or write the one of 256 byte registers that the index selects. The index does not step forward after a data access, so repeated data accesses keep hitting the same register.

A handful of fields are decoded into registered control outputs that other blocks of the chip consume:
- a fast A20 gate enable, from register 01h bit 0;
- a top-of-memory relocation size, from register 2Dh bits 7:6;
- a CPU wait-state count, from register 33h bits 3 and 0;
- an external cache enable, taken from register 40h bit 3, which is active-low.

Register 00h always reads back with bit 6 set, which tells firmware that an external cache is fitted. The stored value of register 00h is left unchanged by this.

Top module: `cfg_regport`

## Requirements
- R1: A write with io_a0 = 0 loads io_wdata into the index. A read with io_a0 = 0 returns the current index on io_rdata.
- R2: A write with io_a0 = 1 stores io_wdata into the register the index selects. A read with io_a0 = 1 returns that register. Neither access changes the index.
- R3: After reset, register 00h holds 40h, register 02h holds 0Ch, register 40h holds 08h, every other register holds 00h, and the index is 00h.
- R4: A data-port read of register 00h returns the stored value ORed with 40h. All other bits are returned as stored.
- R5: a20_fast_en follows bit 0 of register 01h.
- R6: reloc_sel encodes register 2Dh bits 7:6 as follows: 11 gives 2'b10 (384 KB), 10 gives 2'b01 (256 KB), and 00 or 01 gives 2'b00 (none).
- R7: wait_states is set by register 33h bit 3 and bit 0, written here as {bit3,bit0}. The value 00 gives 0, 10 gives 1, 11 gives 2, and 01 gives 0. The value 3 never appears on wait_states.
- R8: ext_cache_en is the inverse of register 40h bit 3. It is 0 after reset.
- R9: Each decoded output changes at the clock edge after the edge that stores the register write. During the cycle between those two edges it still shows the old value.
- R10: io_rdata is 00h whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronous to clk |
| io_a0 | input | 1 | Port select: 0 selects the index port, 1 selects the data port |
| io_wr | input | 1 | Write strobe, sampled on the rising edge of clk |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| a20_fast_en | output | 1 | Fast A20 gate enable |
| reloc_sel | output | 2 | Relocation size: 00 none, 01 256 KB, 10 384 KB |
| wait_states | output | 2 | CPU wait-state count, 0 to 2 |
| ext_cache_en | output | 1 | External cache enable |

## Verification
The hardest cases to reach are those where a stored value differs from what the ports naturally show.

The first is register 00h with bit 6 cleared in storage. It is reached by writing 00h through the data port and then reading the register back. The read must still show bit 6 set while the other bits come back exactly as written.

The second is the one-cycle window of R9, in which the register already holds the new value but the decoded output does not yet. The bench samples the output at the first falling edge after the write edge and again one cycle later.

The third is the unlisted wait-state code {bit3,bit0} = 01. It is reached by writing 01h to register 33h directly after a value that produced 2 wait states, so that a fallback to 0 shows up as a change on wait_states.

// File: rtl/cfg_regport_pkg.sv
package cfg_regport_pkg;

  typedef enum logic [1:0] {
    RELOC_NONE = 2'b00,
    RELOC_256K = 2'b01,
    RELOC_384K = 2'b10
  } reloc_e;

  localparam logic [7:0] ADDR_ID    = 8'h00;
  localparam logic [7:0] ADDR_A20   = 8'h01;
  localparam logic [7:0] ADDR_CLK   = 8'h02;
  localparam logic [7:0] ADDR_RELOC = 8'h2D;
  localparam logic [7:0] ADDR_WAIT  = 8'h33;
  localparam logic [7:0] ADDR_CACHE = 8'h40;

  localparam logic [7:0] CACHE_PRESENT_MASK = 8'h40;

  function automatic logic [7:0] reg_reset_value(input int unsigned idx);
    logic [7:0] v;
    case (idx)
      32'h00:  v = 8'h40;
      32'h02:  v = 8'h0C;
      32'h40:  v = 8'h08;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cfg_regport_index.sv
module cfg_regport_index #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_val,
  output logic [IDX_W-1:0] idx_q
);

  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (ld_en) idx_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (ld_en) idx_q <= idx_d;
  end

endmodule

// File: rtl/cfg_regport_bank.sv
module cfg_regport_bank #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 256,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] regs_q [NUM_REGS]
);

  import cfg_regport_pkg::*;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(reg_reset_value(g));
    logic              we;
    logic [DATA_W-1:0] q;

    always_comb we = wr_en && (sel_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= wdata;
    end

    assign regs_q[g] = q;
  end

  always_comb rd_data = regs_q[sel_idx];

endmodule

// File: rtl/cfg_regport_decode.sv
module cfg_regport_decode #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a20_reg,
  input  logic [DATA_W-1:0] reloc_reg,
  input  logic [DATA_W-1:0] wait_reg,
  input  logic [DATA_W-1:0] cache_reg,
  output logic              a20_fast_en,
  output logic [1:0]        reloc_sel,
  output logic [1:0]        wait_states,
  output logic              ext_cache_en
);

  import cfg_regport_pkg::*;

  logic   a20_d;
  reloc_e reloc_d;
  logic [1:0] ws_d;
  logic   cache_d;

  always_comb begin
    a20_d = a20_reg[0];

    case (reloc_reg[7:6])
      2'b11:   reloc_d = RELOC_384K;
      2'b10:   reloc_d = RELOC_256K;
      default: reloc_d = RELOC_NONE;
    endcase

    case ({wait_reg[3], wait_reg[0]})
      2'b10:   ws_d = 2'd1;
      2'b11:   ws_d = 2'd2;
      default: ws_d = 2'd0;
    endcase

    cache_d = ~cache_reg[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a20_fast_en  <= 1'b0;
      reloc_sel    <= RELOC_NONE;
      wait_states  <= 2'd0;
      ext_cache_en <= 1'b0;
    end else begin
      a20_fast_en  <= a20_d;
      reloc_sel    <= reloc_d;
      wait_states  <= ws_d;
      ext_cache_en <= cache_d;
    end
  end

endmodule

// File: rtl/cfg_regport.sv
module cfg_regport #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_a0,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              a20_fast_en,
  output logic [1:0]        reloc_sel,
  output logic [1:0]        wait_states,
  output logic              ext_cache_en
);

  import cfg_regport_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0]  idx_q;
  logic              idx_ld;
  logic              data_wr;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] data_rd;
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_comb begin
    idx_ld  = io_wr && !io_a0;
    data_wr = io_wr &&  io_a0;
  end

  cfg_regport_index #(.IDX_W(IDX_W)) i_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (idx_ld),
    .ld_val (io_wdata[IDX_W-1:0]),
    .idx_q  (idx_q)
  );

  cfg_regport_bank #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (data_wr),
    .sel_idx (idx_q),
    .wdata   (io_wdata),
    .rd_data (bank_rd),
    .regs_q  (regs_q)
  );

  cfg_regport_decode #(.DATA_W(DATA_W)) i_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .a20_reg      (regs_q[ADDR_A20]),
    .reloc_reg    (regs_q[ADDR_RELOC]),
    .wait_reg     (regs_q[ADDR_WAIT]),
    .cache_reg    (regs_q[ADDR_CACHE]),
    .a20_fast_en  (a20_fast_en),
    .reloc_sel    (reloc_sel),
    .wait_states  (wait_states),
    .ext_cache_en (ext_cache_en)
  );

  always_comb begin
    data_rd = bank_rd;
    if (idx_q == IDX_W'(ADDR_ID)) data_rd = bank_rd | DATA_W'(CACHE_PRESENT_MASK);
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) io_rdata = io_a0 ? data_rd : DATA_W'(idx_q);
  end

endmodule

// File: rtl/cfg_regport_chk.sv
module cfg_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_a0,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic [7:0] idx_q,
  input logic [7:0] r_a20,
  input logic [7:0] r_reloc,
  input logic [7:0] r_wait,
  input logic [7:0] r_cache,
  input logic       a20_fast_en,
  input logic [1:0] reloc_sel,
  input logic [1:0] wait_states,
  input logic       ext_cache_en
);

  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_a0) |=> (idx_q == $past(io_wdata)));

  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_a0) |=> $stable(idx_q));

  p_id_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_a0 && idx_q == 8'h00) |-> io_rdata[6]);

  p_a20_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    a20_fast_en == $past(r_a20[0]));

  p_reloc_big_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_sel == 2'b10) |-> ($past(r_reloc[7:6]) == 2'b11));

  p_ws_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_states != 2'd3);

  p_cache_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cache_en == !$past(r_cache[3]));

  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));

endmodule

bind cfg_regport cfg_regport_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_a0        (io_a0),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .idx_q        (idx_q),
  .r_a20        (regs_q[1]),
  .r_reloc      (regs_q[45]),
  .r_wait       (regs_q[51]),
  .r_cache      (regs_q[64]),
  .a20_fast_en  (a20_fast_en),
  .reloc_sel    (reloc_sel),
  .wait_states  (wait_states),
  .ext_cache_en (ext_cache_en)
);

// File: tb/test_cfg_regport.sv
module test_cfg_regport;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       io_a0, io_wr, io_rd;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  logic       a20_fast_en;
  logic [1:0] reloc_sel;
  logic [1:0] wait_states;
  logic       ext_cache_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  cfg_regport i_cfg_regport (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_a0        (io_a0),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .a20_fast_en  (a20_fast_en),
    .reloc_sel    (reloc_sel),
    .wait_states  (wait_states),
    .ext_cache_en (ext_cache_en)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a0, input logic [7:0] d);
    @(negedge clk);
    io_a0 = a0; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic a0, output logic [7:0] d);
    @(negedge clk);
    io_a0 = a0; io_rd = 1'b1;
    #2 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
    bus_wr(1'b0, idx);
    bus_wr(1'b1, val);
  endtask

  task automatic get_reg(input logic [7:0] idx, output logic [7:0] val);
    bus_wr(1'b0, idx);
    bus_rd(1'b1, val);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_rd(1'b0, v);  check("R3 index after reset", v, 8'h00);
    get_reg(8'h00, v); check("R3 reg00", v, 8'h40);
    get_reg(8'h02, v); check("R3 reg02", v, 8'h0C);
    get_reg(8'h40, v); check("R3 reg40", v, 8'h08);
    get_reg(8'h2D, v); check("R3 reg2D", v, 8'h00);
    get_reg(8'hFF, v); check("R3 regFF", v, 8'h00);
    check("R3 a20", {7'd0, a20_fast_en}, 8'h00);
    check("R3 reloc", {6'd0, reloc_sel}, 8'h00);
    check("R3 ws", {6'd0, wait_states}, 8'h00);
    check("R8 cache after reset", {7'd0, ext_cache_en}, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] v;
    bus_wr(1'b0, 8'hA5); bus_rd(1'b0, v); check("R1 index A5", v, 8'hA5);
    bus_wr(1'b0, 8'h5A); bus_rd(1'b0, v); check("R1 index 5A", v, 8'h5A);
  endtask

  task automatic t_data();
    logic [7:0] v;
    set_reg(8'h10, 8'h3C);
    set_reg(8'h11, 8'hC3);
    set_reg(8'hFE, 8'h81);
    get_reg(8'h10, v); check("R2 reg10", v, 8'h3C);
    get_reg(8'h11, v); check("R2 reg11", v, 8'hC3);
    get_reg(8'hFE, v); check("R2 regFE", v, 8'h81);
    bus_rd(1'b1, v);   check("R2 repeat read", v, 8'h81);
    bus_rd(1'b0, v);   check("R2 no increment", v, 8'hFE);
    bus_wr(1'b1, 8'h7E);
    bus_rd(1'b0, v);   check("R2 index after data write", v, 8'hFE);
    bus_rd(1'b1, v);   check("R2 overwrite", v, 8'h7E);
    get_reg(8'h10, v); check("R2 neighbour untouched", v, 8'h3C);
  endtask

  task automatic t_id();
    logic [7:0] v;
    set_reg(8'h00, 8'h00);
    bus_rd(1'b1, v); check("R4 bit6 forced", v, 8'h40);
    set_reg(8'h00, 8'h85);
    bus_rd(1'b1, v); check("R4 other bits kept", v, 8'hC5);
    set_reg(8'h01, 8'h00);
    bus_rd(1'b1, v); check("R4 only reg00", v, 8'h00);
  endtask

  task automatic t_a20();
    set_reg(8'h01, 8'h01);
    check("R9 a20 still old", {7'd0, a20_fast_en}, 8'h00);
    @(negedge clk);
    check("R5 a20 set", {7'd0, a20_fast_en}, 8'h01);
    set_reg(8'h01, 8'hFE);
    check("R9 a20 old before lag", {7'd0, a20_fast_en}, 8'h01);
    @(negedge clk);
    check("R5 a20 clear", {7'd0, a20_fast_en}, 8'h00);
  endtask

  task automatic t_reloc();
    set_reg(8'h2D, 8'hC0); @(negedge clk); check("R6 reloc 11", {6'd0, reloc_sel}, 8'h02);
    set_reg(8'h2D, 8'h80); @(negedge clk); check("R6 reloc 10", {6'd0, reloc_sel}, 8'h01);
    set_reg(8'h2D, 8'h7F); @(negedge clk); check("R6 reloc 01", {6'd0, reloc_sel}, 8'h00);
    set_reg(8'h2D, 8'hC0); @(negedge clk);
    set_reg(8'h2D, 8'h3F); @(negedge clk); check("R6 reloc 00", {6'd0, reloc_sel}, 8'h00);
  endtask

  task automatic t_wait();
    set_reg(8'h33, 8'h08); @(negedge clk); check("R7 ws 10", {6'd0, wait_states}, 8'h01);
    set_reg(8'h33, 8'h09);
    check("R9 ws old", {6'd0, wait_states}, 8'h01);
    @(negedge clk); check("R7 ws 11", {6'd0, wait_states}, 8'h02);
    set_reg(8'h33, 8'h01); @(negedge clk); check("R7 ws 01 fallback", {6'd0, wait_states}, 8'h00);
    set_reg(8'h33, 8'hF6); @(negedge clk); check("R7 ws 00", {6'd0, wait_states}, 8'h00);
  endtask

  task automatic t_cache();
    set_reg(8'h40, 8'h00); @(negedge clk); check("R8 cache on", {7'd0, ext_cache_en}, 8'h01);
    set_reg(8'h40, 8'hF7); @(negedge clk); check("R8 other bits", {7'd0, ext_cache_en}, 8'h01);
    set_reg(8'h40, 8'h08);
    check("R9 cache old", {7'd0, ext_cache_en}, 8'h01);
    @(negedge clk); check("R8 cache off", {7'd0, ext_cache_en}, 8'h00);
  endtask

  task automatic t_quiet();
    bus_wr(1'b0, 8'h00);
    @(negedge clk);
    io_a0 = 1'b1; #2;
    check("R10 idle data port", io_rdata, 8'h00);
    io_a0 = 1'b0; #2;
    check("R10 idle index port", io_rdata, 8'h00);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; io_a0 = 1'b0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_data();
    t_id();
    t_a20();
    t_reloc();
    t_wait();
    t_cache();
    t_quiet();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

endmodule